// File: doc/BRIEF.md
# Length-Framed Stream Packet FIFO

This block buffers packets between two 16-bit streams. Both streams move one word per clock using a strobe/acknowledge handshake. Each packet begins with a header word that gives its length in bytes. The data words that follow carry those bytes two to a word. The buffer takes packets from its upstream stream and holds them in a word store of configurable depth. It hands a packet downstream only once every word of that packet has arrived, so the consumer never stalls in the middle of a packet waiting for the producer.

When the store fills, the upstream acknowledge is withdrawn until space frees up. Nothing is ever dropped. The downstream strobe rises as soon as a stored word is eligible, without waiting for the consumer to acknowledge. Reset empties the buffer and silences both handshake outputs.

Top module: `lenframe_pkt_fifo`

## Requirements
- R1: A word moves on a rising clock edge where strobe and acknowledge are both 1. When the store is far from full and a whole packet is stored, words move on consecutive cycles on both sides, and neither signal needs to return to 0 between words.
- R2: While `rst` is 1 at a rising edge, `in_ack` and `out_stb` are 0 after that edge, and every stored word is discarded.
- R3: Once `out_stb` is 1, it stays at 1 and `out_data` stays unchanged until the edge at which `out_ack` is also 1.
- R4: Once `in_ack` is 1, it stays at 1 until the edge at which `in_stb` is also 1.
- R5: The first word of every packet is an unsigned byte count L. It is followed by exactly ceil(L/2) data words, and the word after those is the next packet's header.
- R6: Packets leave in arrival order with every word unchanged. The output presents a header only when all ceil(L/2)+1 words of that packet are already stored.
- R7: The store holds `DEPTH` words, with a default of 1024. `in_ack` is 0 when the store is full, and no word is lost. With the output stalled, the block accepts exactly `DEPTH`+1 words, because the header of the first complete packet moves into the output register.
- R8: A header with L = 0 is forwarded as a one-word packet. The next word on the output is the next packet's header.
- R9: `out_stb` rises for an eligible word while `out_ack` is 0. It never waits for the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 16 | Upstream word (header or data) |
| in_stb | input | 1 | Upstream word valid |
| in_ack | output | 1 | Buffer ready to accept a word |
| out_data | output | 16 | Downstream word |
| out_stb | output | 1 | Downstream word valid |
| out_ack | input | 1 | Consumer ready to accept a word |

## Verification
The assertions assume that the upstream producer obeys the handshake and sends well-formed packets. Each packet must have no more than `DEPTH` words in total, or it could never complete and the buffer would wait forever. The stimulus builds every packet from its own byte count. It holds `in_stb` and `in_data` steady until the word is taken, and keeps every packet far below the store size. The bench drops its own acknowledge stickiness only when it deliberately stalls the output completely. The block places no rule on the consumer's behaviour.

// File: rtl/lfq_pkg.sv
package lfq_pkg;
  localparam int WORD_W = 16;

  // Number of data words that carry a given byte count (two bytes per word).
  function automatic logic [WORD_W-1:0] len_to_words(input logic [WORD_W-1:0] len_bytes);
    return (len_bytes >> 1) + {{(WORD_W-1){1'b0}}, len_bytes[0]};
  endfunction
endpackage

// File: rtl/lfq_frame_track.sv
module lfq_frame_track (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fire,
  input  logic [lfq_pkg::WORD_W-1:0] word,
  output logic                       at_header,
  output logic                       frame_end
);
  localparam int W = lfq_pkg::WORD_W;

  logic [W-1:0] rem_q;
  logic [W-1:0] hdr_words;

  assign hdr_words = lfq_pkg::len_to_words(word);
  assign at_header = (rem_q == '0);
  assign frame_end = fire && (at_header ? (hdr_words == '0) : (rem_q == W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
    end else if (fire) begin
      rem_q <= at_header ? hdr_words : rem_q - W'(1);
    end
  end

  // R5: the tracker loads a new count only from a header word.
  assert_hdr_count_R5: assert property (@(posedge clk) disable iff (rst)
    (fire && at_header) |=> (rem_q == $past(hdr_words)));
endmodule

// File: rtl/lfq_store.sv
module lfq_store #(
  parameter int DEPTH = 1024
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_stb,
  input  logic [lfq_pkg::WORD_W-1:0]           wr_data,
  output logic                                 wr_ack,
  input  logic                                 rd_en,
  output logic [lfq_pkg::WORD_W-1:0]           rd_data,
  output logic                                 empty,
  output logic [$clog2(DEPTH+1)-1:0]           occ
);
  localparam int W  = lfq_pkg::WORD_W;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          ack_q;
  logic          wr_en;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign wr_en   = wr_stb && ack_q;
  assign wr_ack  = ack_q;
  assign rd_data = mem[rp_q];
  assign empty   = (cnt_q == '0);
  assign occ     = cnt_q;
  assign cnt_nx  = cnt_q + CW'(wr_en) - CW'(rd_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else begin
      if (wr_en) wp_q <= bump(wp_q);
      if (rd_en) rp_q <= bump(rp_q);
      cnt_q <= cnt_nx;
      ack_q <= (cnt_nx < CW'(DEPTH));
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_data;
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (cnt_q < CW'(DEPTH)));

  assert_ack_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (ack_q && !wr_stb) |=> ack_q);

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (cnt_q != '0));
endmodule

// File: rtl/lfq_release.sv
module lfq_release #(
  parameter int DEPTH = 1024
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frame_done,
  input  logic                       empty,
  input  logic [lfq_pkg::WORD_W-1:0] rd_data,
  input  logic                       at_header,
  input  logic                       out_ack,
  output logic                       load,
  output logic                       out_stb,
  output logic [lfq_pkg::WORD_W-1:0] out_data
);
  localparam int W  = lfq_pkg::WORD_W;
  localparam int RW = $clog2(DEPTH + 2);

  logic [RW-1:0] ready_q;
  logic          can_take;
  logic          eligible;
  logic          hdr_out;

  assign can_take = !out_stb || out_ack;
  assign eligible = !empty && (!at_header || (ready_q != '0));
  assign load     = can_take && eligible;
  assign hdr_out  = load && at_header;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q  <= '0;
      out_stb  <= 1'b0;
      out_data <= '0;
    end else begin
      ready_q <= ready_q + RW'(frame_done) - RW'(hdr_out);
      if (load) begin
        out_stb  <= 1'b1;
        out_data <= rd_data;
      end else if (out_ack) begin
        out_stb  <= 1'b0;
      end
    end
  end

  assert_stb_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (out_stb && !out_ack) |=> (out_stb && $stable(out_data)));

  // R9: an eligible word is shown even while the consumer is not ready.
  assert_no_wait_R9: assert property (@(posedge clk) disable iff (rst)
    (!out_stb && eligible) |=> out_stb);
endmodule

// File: rtl/lenframe_pkt_fifo.sv
module lenframe_pkt_fifo #(
  parameter int DEPTH = 1024
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] in_data,
  input  logic        in_stb,
  output logic        in_ack,
  output logic [15:0] out_data,
  output logic        out_stb,
  input  logic        out_ack
);
  localparam int W  = lfq_pkg::WORD_W;
  localparam int CW = $clog2(DEPTH + 1);

  logic          in_fire;
  logic          in_at_header;
  logic          in_frame_done;
  logic          st_empty;
  logic [W-1:0]  st_rd_data;
  logic [CW-1:0] st_occ;
  logic          eg_load;
  logic          eg_at_header;
  logic          eg_frame_end;

  assign in_fire = in_stb && in_ack;

  lfq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .wr_stb(in_stb), .wr_data(in_data), .wr_ack(in_ack),
    .rd_en(eg_load), .rd_data(st_rd_data), .empty(st_empty), .occ(st_occ)
  );

  lfq_frame_track u_in_track (
    .clk(clk), .rst(rst), .fire(in_fire), .word(in_data),
    .at_header(in_at_header), .frame_end(in_frame_done)
  );

  lfq_frame_track u_out_track (
    .clk(clk), .rst(rst), .fire(eg_load), .word(st_rd_data),
    .at_header(eg_at_header), .frame_end(eg_frame_end)
  );

  lfq_release #(.DEPTH(DEPTH)) u_release (
    .clk(clk), .rst(rst), .frame_done(in_frame_done), .empty(st_empty),
    .rd_data(st_rd_data), .at_header(eg_at_header), .out_ack(out_ack),
    .load(eg_load), .out_stb(out_stb), .out_data(out_data)
  );

  // R6: a header leaves the store only with its whole packet behind it.
  assert_frame_stored_R6: assert property (@(posedge clk) disable iff (rst)
    (eg_load && eg_at_header) |->
      (int'(st_occ) >= int'(lfq_pkg::len_to_words(st_rd_data)) + 1));

  // R8: a zero-length header ends its packet on the output side at once.
  assert_empty_frame_R8: assert property (@(posedge clk) disable iff (rst)
    (eg_load && eg_at_header && (st_rd_data == '0)) |-> eg_frame_end);

  assert_reset_quiet_R2: assert property (@(posedge clk)
    rst |=> (!in_ack && !out_stb));

  // R2: the input side expects a header once reset ends.
  assert_reset_header_R2: assert property (@(posedge clk)
    rst |=> in_at_header);
endmodule

// File: tb/test_lenframe_pkt_fifo.sv
module test_lenframe_pkt_fifo;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] in_data = '0;
  logic        in_stb = 1'b0;
  logic        in_ack;
  logic [15:0] out_data;
  logic        out_stb;
  logic        out_ack = 1'b0;

  always #4 clk = ~clk;

  lenframe_pkt_fifo #(.DEPTH(DEPTH)) i_lenframe_pkt_fifo (
    .clk(clk), .rst(rst), .in_data(in_data), .in_stb(in_stb), .in_ack(in_ack),
    .out_data(out_data), .out_stb(out_stb), .out_ack(out_ack)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [15:0] gen_q[$];
  logic [15:0] model_q[$];
  int in_rem = 0, out_rem = 0, frames_in = 0, frames_out = 0, in_acc = 0;
  int in_rate = 100, out_rate = 100;
  bit fast = 0;
  int last_out = -10;
  logic s_is = 0, s_ia = 0, s_os = 0, s_oa = 0;
  logic [15:0] s_id = '0, s_od = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic add_frame(input int len);
    gen_q.push_back(16'(len));
    for (int i = 0; i < (len + 1) / 2; i++) gen_q.push_back(16'($urandom));
  endtask

  task automatic save_now();
    s_is = in_stb; s_id = in_data; s_ia = in_ack;
    s_os = out_stb; s_od = out_data; s_oa = out_ack;
  endtask

  task automatic step();
    logic [15:0] w;
    @(negedge clk);
    cyc++;
    // words that moved at the edge just passed
    if (s_is && s_ia) begin
      model_q.push_back(s_id);
      void'(gen_q.pop_front());
      in_acc++;
      if (in_rem == 0) begin
        in_rem = (int'(s_id) + 1) / 2;
        if (in_rem == 0) frames_in++;
      end else begin
        in_rem--;
        if (in_rem == 0) frames_in++;
      end
    end
    if (s_os && s_oa) begin
      w = model_q.pop_front();
      if (out_rem == 0) begin
        out_rem = (int'(w) + 1) / 2;
        frames_out++;
      end else begin
        out_rem--;
        if (fast) chk(last_out == cyc - 1, "R1 data words back to back", cyc - last_out, 1);
      end
      last_out = cyc;
    end
    // port checks against the model
    if (s_os && !s_oa)
      chk(out_stb === 1'b1 && out_data === s_od, "R3 strobe and data held", int'(out_data), int'(s_od));
    if (s_ia && !s_is)
      chk(in_ack === 1'b1, "R4 ack held", int'(in_ack), 1);
    if (out_stb === 1'b1) begin
      if (model_q.size() == 0) chk(0, "R6 word with nothing accepted", int'(out_data), -1);
      else chk(out_data === model_q[0], "R6 word order and value", int'(out_data), int'(model_q[0]));
      if (out_rem == 0) chk(frames_in > frames_out, "R6 header before packet complete", frames_in, frames_out + 1);
    end
    if (fast) chk(in_ack === 1'b1, "R1 input ready every cycle", int'(in_ack), 1);
    // drive for the next edge
    if (!(s_is && !s_ia)) begin
      if (gen_q.size() > 0 && int'($urandom % 100) < in_rate) begin
        in_stb = 1'b1; in_data = gen_q[0];
      end else begin
        in_stb = 1'b0; in_data = 16'($urandom);
      end
    end
    if (!(s_oa && !s_os && out_rate != 0))
      out_ack = (int'($urandom % 100) < out_rate);
    save_now();
  endtask

  task automatic drain();
    for (int i = 0; i < 30000; i++) begin
      if (gen_q.size() == 0 && model_q.size() == 0 && !out_stb) break;
      step();
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen;
    int acc0;
    repeat (4) @(negedge clk);
    chk(in_ack === 1'b0, "R2 ack low in reset", int'(in_ack), 0);
    chk(out_stb === 1'b0, "R2 strobe low in reset", int'(out_stb), 0);
    rst = 1'b0;
    save_now();

    // R1 and R5: mixed lengths at full rate on both sides
    for (int i = 0; i < 5; i++) step();
    fast = 1;
    add_frame(0); add_frame(1); add_frame(2); add_frame(5); add_frame(8); add_frame(21);
    drain();
    fast = 0;
    chk(frames_in == 6 && frames_out == 6, "R5 packet count from byte lengths", frames_out, 6);

    // R8: zero-length packet alone, output stalled
    out_rate = 0;
    add_frame(0);
    for (int i = 0; i < 10; i++) step();
    chk(out_stb === 1'b1 && out_data === 16'd0, "R8 empty packet shown", int'(out_data), 0);
    out_rate = 100;
    add_frame(3);
    drain();
    chk(frames_out == 8 && model_q.size() == 0, "R8 next header follows", frames_out, 8);

    // R6: partial packet must not be released
    gen_q.push_back(16'd10); gen_q.push_back(16'h1111); gen_q.push_back(16'h2222);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (out_stb === 1'b1) seen = 1;
    end
    chk(!seen, "R6 partial packet held", int'(seen), 0);
    gen_q.push_back(16'h3333); gen_q.push_back(16'h4444); gen_q.push_back(16'h5555);
    drain();
    chk(frames_out == 9, "R6 completed packet released", frames_out, 9);

    // R3 and R4 under random gaps
    in_rate = 60; out_rate = 50;
    for (int i = 0; i < 40; i++) add_frame(int'($urandom % 41));
    drain();
    chk(frames_out == frames_in && frames_in == 49, "R6 all random packets out", frames_out, 49);

    // R7 and R9: fill the store with the output stalled
    in_rate = 100; out_rate = 0;
    acc0 = in_acc;
    for (int i = 0; i < 100; i++) add_frame(20);
    for (int i = 0; i < 1300; i++) step();
    chk(in_acc - acc0 == DEPTH + 1, "R7 words accepted when full", in_acc - acc0, DEPTH + 1);
    chk(in_ack === 1'b0, "R7 ack low when full", int'(in_ack), 0);
    chk(out_stb === 1'b1 && out_data === 16'd20, "R9 strobe without ack", int'(out_stb), 1);
    out_rate = 100;
    drain();
    chk(frames_out == 149 && model_q.size() == 0, "R7 no word lost", frames_out, 149);

    // R2: reset in the middle of traffic
    in_rate = 70; out_rate = 40;
    for (int i = 0; i < 10; i++) add_frame(30);
    for (int i = 0; i < 60; i++) step();
    @(negedge clk);
    rst = 1'b1; in_stb = 1'b0; out_ack = 1'b0;
    repeat (2) @(negedge clk);
    chk(in_ack === 1'b0 && out_stb === 1'b0, "R2 outputs quiet in reset", int'(in_ack) + int'(out_stb), 0);
    gen_q.delete(); model_q.delete();
    in_rem = 0; out_rem = 0; frames_in = 0; frames_out = 0;
    rst = 1'b0;
    save_now();
    for (int i = 0; i < 3; i++) step();
    chk(out_stb === 1'b0, "R2 store emptied", int'(out_stb), 0);
    add_frame(7); add_frame(0); add_frame(12);
    drain();
    chk(frames_out == 3 && frames_in == 3, "R2 clean after reset", frames_out, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule